// File: doc/BRIEF.md
# DRAM Reclock Command Sequencer

This block sits on the controller side of a DRAM interface. It walks the memory through a safe change of its input clock. A single start pulse captures three things: the memory type, the three mode-register values now in the device (MR0, MR1, MR2) and the three values wanted after the change. The block then produces an ordered stream of commands on a valid/ready command port.

The stream has four parts, in this order:
- An optional step that switches the DLL off.
- A self-refresh entry, then a clock-change request, then a self-refresh exit.
- Mode-register writes, issued only for registers whose value changes, followed by a timing-register load.
- An optional DLL enable and reset with a lock wait.

Fixed delays are inserted between the commands. The delays are given in nanoseconds and chosen by memory type. They are turned into clock cycles through a clock-period parameter. When the sequence ends, the block pulses a done output. A type the block does not support ends the run at once: no command is issued and a sticky error flag is raised.

Top module: `reclk_seq`

## Requirements
- R1: mem_type code 3 is unsupported. A start with that code issues no command, pulses done in the cycle after the start, and holds err high until the next accepted start. Codes 0 (DDR2), 1 (DDR3) and 2 (GDDR3) clear err on start.
- R2: The DLL-off flag is MR1 bit 0 for codes 0 and 1, and MR1 bit 6 for code 2. Other MR1 bits never count as the flag.
- R3: If the current MR1 has the flag clear and the target MR1 has it set, the sequence begins with a precharge. It then writes MR1 (cmd_sel 1) with the current value plus the flag, then waits the settle time.
- R4: Self-refresh entry issues, in order: precharge, refresh, refresh, auto-refresh with data bit 0 = 0, and self-refresh with data bit 0 = 1. The entry wait follows, then one clock-change request.
- R5: Self-refresh exit issues, in order: precharge, self-refresh with data 0, and auto-refresh with data 1. The exit wait then follows twice back to back.
- R6: Mode registers are written in the order MR2, MR1, MR0. Each write happens only when the target differs from the current value, and each is followed by the settle wait. The MR1 value written is the target ORed with the current flag bit. A timing-register load comes next.
- R7: If the target has the flag clear, a final phase follows. It writes the full target MR1 only if the current flag is set. It then writes MR0 with bit 8 set, then MR0 plain; each of these writes is followed by a settle wait. A DLL lock wait follows, and for code 2 only a closing precharge.
- R8: For code 0, the target MR2 is taken as the current MR2, so MR2 is never written.
- R9: A wait of N ns lasts ceil(N / CLK_PERIOD_NS) idle cycles, and a zero wait lasts no cycles. Waits by memory type:
  - Settle: 1000 ns for all types.
  - Lock: 2000 ns for DDR2, 12000 ns for DDR3, 40000 ns for GDDR3.
  - Entry wait: 2000 ns for DDR3, 0 otherwise.
  - Exit wait: 1000 ns for DDR3, 0 otherwise.
  - Clock-stable wait before exit: 0.
- R10: Command codes on cmd_op: 0 precharge, 1 refresh, 2 auto-refresh, 3 self-refresh, 4 mode-register set, 5 clock-change, 6 timing load. A command stays valid with stable fields until cmd_ready. It is consumed at the first edge where valid and ready are both high.
- R11: After the last command or wait, done is high for exactly one cycle with no command valid. A start that arrives while a run is in progress, including its done cycle, is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| mem_type | input | 2 | 0 DDR2, 1 DDR3, 2 GDDR3, 3 unsupported |
| cur_mr0 | input | MR_W | MR0 value now in the device |
| cur_mr1 | input | MR_W | MR1 value now in the device |
| cur_mr2 | input | MR_W | MR2 value now in the device |
| tgt_mr0 | input | MR_W | Wanted MR0 |
| tgt_mr1 | input | MR_W | Wanted MR1 |
| tgt_mr2 | input | MR_W | Wanted MR2 |
| cmd_valid | output | 1 | A command is offered |
| cmd_ready | input | 1 | Command path accepts the command |
| cmd_op | output | 3 | Command code |
| cmd_sel | output | 2 | Mode-register index for command 4 |
| cmd_data | output | MR_W | Mode-register value, or enable bit for commands 2 and 3 |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Sticky unsupported-type flag |

## Verification
Two events can meet in one cycle: a new start and a run that is still busy. This includes the done cycle, where the start lands on the very edge at which the block returns to idle. The bench raises start, with an unsupported type on the inputs, once in the middle of a GDDR3 run and once during the done cycle of another run. It also stalls cmd_ready two cycles in three, so that a handshake falls on the same edge as other state changes. Each of these runs is judged against a cycle-by-cycle reference stream: any extra command, change of err, or shift of done fails the comparison.

// File: rtl/reclk_pkg.sv
package reclk_pkg;

   typedef logic [5:0] step_t;

   localparam int NSTEP = 33;

   localparam step_t ST_BEGIN       = 6'd0;
   localparam step_t ST_OFF_PRE     = 6'd1;
   localparam step_t ST_OFF_MRS     = 6'd2;
   localparam step_t ST_OFF_WAIT    = 6'd3;
   localparam step_t ST_SR_PRE      = 6'd4;
   localparam step_t ST_SR_REF_A    = 6'd5;
   localparam step_t ST_SR_REF_B    = 6'd6;
   localparam step_t ST_SR_AUTO_OFF = 6'd7;
   localparam step_t ST_SR_SELF_ON  = 6'd8;
   localparam step_t ST_SR_WAIT     = 6'd9;
   localparam step_t ST_CLK         = 6'd10;
   localparam step_t ST_XS_CLKWAIT  = 6'd11;
   localparam step_t ST_XS_PRE      = 6'd12;
   localparam step_t ST_XS_SELF_OFF = 6'd13;
   localparam step_t ST_XS_AUTO_ON  = 6'd14;
   localparam step_t ST_XS_WAIT_A   = 6'd15;
   localparam step_t ST_XS_WAIT_B   = 6'd16;
   localparam step_t ST_MR2         = 6'd17;
   localparam step_t ST_MR2_WAIT    = 6'd18;
   localparam step_t ST_MR1         = 6'd19;
   localparam step_t ST_MR1_WAIT    = 6'd20;
   localparam step_t ST_MR0         = 6'd21;
   localparam step_t ST_MR0_WAIT    = 6'd22;
   localparam step_t ST_TIMING      = 6'd23;
   localparam step_t ST_ON_MR1      = 6'd24;
   localparam step_t ST_ON_MR1_WAIT = 6'd25;
   localparam step_t ST_ON_RST      = 6'd26;
   localparam step_t ST_ON_RST_WAIT = 6'd27;
   localparam step_t ST_ON_MR0      = 6'd28;
   localparam step_t ST_ON_MR0_WAIT = 6'd29;
   localparam step_t ST_ON_LOCK     = 6'd30;
   localparam step_t ST_ON_PRE      = 6'd31;
   localparam step_t ST_FIN         = 6'd32;

   typedef enum logic [1:0] {K_NOP, K_CMD, K_WAIT, K_FIN} kind_e;

   localparam logic [2:0] OP_PRE    = 3'd0;
   localparam logic [2:0] OP_REF    = 3'd1;
   localparam logic [2:0] OP_AUTO   = 3'd2;
   localparam logic [2:0] OP_SELF   = 3'd3;
   localparam logic [2:0] OP_MRS    = 3'd4;
   localparam logic [2:0] OP_CLK    = 3'd5;
   localparam logic [2:0] OP_TIMING = 3'd6;

   localparam logic [1:0] MT_DDR2  = 2'd0;
   localparam logic [1:0] MT_DDR3  = 2'd1;
   localparam logic [1:0] MT_GDDR3 = 2'd2;
   localparam logic [1:0] MT_OTHER = 2'd3;

   function automatic int ceil_div(int num, int den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/reclk_wait_timer.sv
module reclk_wait_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             run,
   input  logic [CNT_W-1:0] limit,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   assign expired = run && (cnt_q == limit - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clear) cnt_q <= '0;
      else if (run)   cnt_q <= cnt_q + CNT_W'(1);
   end

endmodule

// File: rtl/reclk_step_decode.sv
module reclk_step_decode
   import reclk_pkg::*;
#(
   parameter step_t STEP_ID       = ST_BEGIN,
   parameter int    MR_W          = 16,
   parameter int    CNT_W         = 16,
   parameter int    MRD_CYC       = 50,
   parameter int    LOCK_DDR2_CYC = 100,
   parameter int    LOCK_DDR3_CYC = 600,
   parameter int    LOCK_GDD3_CYC = 2000,
   parameter int    SRE_CYC       = 100,
   parameter int    SRX_CYC       = 0,
   parameter int    XS_CYC        = 50
) (
   input  logic [1:0]      typ,
   input  logic [MR_W-1:0] cur0,
   input  logic [MR_W-1:0] cur1,
   input  logic [MR_W-1:0] cur2,
   input  logic [MR_W-1:0] tgt0,
   input  logic [MR_W-1:0] tgt1,
   input  logic [MR_W-1:0] tgt2,
   output logic            en,
   output kind_e           kind,
   output logic [2:0]      op,
   output logic [1:0]      sel,
   output logic [MR_W-1:0] data,
   output logic [CNT_W-1:0] wcyc
);

   logic            is_g3;
   logic            is_d3;
   logic [MR_W-1:0] flag;
   logic            cur_off;
   logic            tgt_off;
   logic            go_off;
   logic            want_on;
   logic [CNT_W-1:0] lock_cyc;

   always_comb begin
      is_g3   = (typ == MT_GDDR3);
      is_d3   = (typ == MT_DDR3);
      flag    = is_g3 ? (MR_W'(1) << 6) : MR_W'(1);
      cur_off = |(cur1 & flag);
      tgt_off = |(tgt1 & flag);
      go_off  = !cur_off && tgt_off;
      want_on = !tgt_off;
      case (typ)
         MT_DDR2: lock_cyc = CNT_W'(LOCK_DDR2_CYC);
         MT_DDR3: lock_cyc = CNT_W'(LOCK_DDR3_CYC);
         default: lock_cyc = CNT_W'(LOCK_GDD3_CYC);
      endcase

      en   = 1'b1;
      kind = K_CMD;
      op   = OP_PRE;
      sel  = 2'd0;
      data = '0;
      wcyc = '0;

      case (STEP_ID)
         ST_BEGIN:       kind = K_NOP;
         ST_OFF_PRE:     en = go_off;
         ST_OFF_MRS: begin
            en = go_off; op = OP_MRS; sel = 2'd1; data = cur1 | flag;
         end
         ST_OFF_WAIT: begin
            en = go_off; kind = K_WAIT; wcyc = CNT_W'(MRD_CYC);
         end
         ST_SR_PRE:      op = OP_PRE;
         ST_SR_REF_A,
         ST_SR_REF_B:    op = OP_REF;
         ST_SR_AUTO_OFF: op = OP_AUTO;
         ST_SR_SELF_ON: begin
            op = OP_SELF; data = MR_W'(1);
         end
         ST_SR_WAIT: begin
            kind = K_WAIT; wcyc = is_d3 ? CNT_W'(SRE_CYC) : '0;
         end
         ST_CLK:         op = OP_CLK;
         ST_XS_CLKWAIT: begin
            kind = K_WAIT; wcyc = CNT_W'(SRX_CYC);
         end
         ST_XS_PRE:      op = OP_PRE;
         ST_XS_SELF_OFF: op = OP_SELF;
         ST_XS_AUTO_ON: begin
            op = OP_AUTO; data = MR_W'(1);
         end
         ST_XS_WAIT_A,
         ST_XS_WAIT_B: begin
            kind = K_WAIT; wcyc = is_d3 ? CNT_W'(XS_CYC) : '0;
         end
         ST_MR2: begin
            en = (cur2 != tgt2); op = OP_MRS; sel = 2'd2; data = tgt2;
         end
         ST_MR2_WAIT: begin
            en = (cur2 != tgt2); kind = K_WAIT; wcyc = CNT_W'(MRD_CYC);
         end
         ST_MR1: begin
            en = (cur1 != tgt1); op = OP_MRS; sel = 2'd1;
            data = tgt1 | (cur1 & flag);
         end
         ST_MR1_WAIT: begin
            en = (cur1 != tgt1); kind = K_WAIT; wcyc = CNT_W'(MRD_CYC);
         end
         ST_MR0: begin
            en = (cur0 != tgt0); op = OP_MRS; sel = 2'd0; data = tgt0;
         end
         ST_MR0_WAIT: begin
            en = (cur0 != tgt0); kind = K_WAIT; wcyc = CNT_W'(MRD_CYC);
         end
         ST_TIMING:      op = OP_TIMING;
         ST_ON_MR1: begin
            en = want_on && cur_off; op = OP_MRS; sel = 2'd1; data = tgt1;
         end
         ST_ON_MR1_WAIT: begin
            en = want_on && cur_off; kind = K_WAIT; wcyc = CNT_W'(MRD_CYC);
         end
         ST_ON_RST: begin
            en = want_on; op = OP_MRS; data = tgt0 | (MR_W'(1) << 8);
         end
         ST_ON_MR0: begin
            en = want_on; op = OP_MRS; data = tgt0;
         end
         ST_ON_RST_WAIT,
         ST_ON_MR0_WAIT: begin
            en = want_on; kind = K_WAIT; wcyc = CNT_W'(MRD_CYC);
         end
         ST_ON_LOCK: begin
            en = want_on; kind = K_WAIT; wcyc = lock_cyc;
         end
         ST_ON_PRE:      en = want_on && is_g3;
         default:        kind = K_FIN;
      endcase

      if (kind == K_WAIT && wcyc == '0) en = 1'b0;
   end

endmodule

// File: rtl/reclk_seq.sv
module reclk_seq
   import reclk_pkg::*;
#(
   parameter int MR_W             = 16,
   parameter int CNT_W            = 16,
   parameter int CLK_PERIOD_NS    = 20,
   parameter int T_MRD_NS         = 1000,
   parameter int T_LOCK_DDR2_NS   = 2000,
   parameter int T_LOCK_DDR3_NS   = 12000,
   parameter int T_LOCK_GDDR3_NS  = 40000,
   parameter int T_SR_ENTRY_NS    = 2000,
   parameter int T_CLK_STABLE_NS  = 0,
   parameter int T_SR_EXIT_NS     = 1000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [1:0]      mem_type,
   input  logic [MR_W-1:0] cur_mr0,
   input  logic [MR_W-1:0] cur_mr1,
   input  logic [MR_W-1:0] cur_mr2,
   input  logic [MR_W-1:0] tgt_mr0,
   input  logic [MR_W-1:0] tgt_mr1,
   input  logic [MR_W-1:0] tgt_mr2,
   output logic            cmd_valid,
   input  logic            cmd_ready,
   output logic [2:0]      cmd_op,
   output logic [1:0]      cmd_sel,
   output logic [MR_W-1:0] cmd_data,
   output logic            done,
   output logic            err
);

   localparam int MRD_CYC   = ceil_div(T_MRD_NS, CLK_PERIOD_NS);
   localparam int LK2_CYC   = ceil_div(T_LOCK_DDR2_NS, CLK_PERIOD_NS);
   localparam int LK3_CYC   = ceil_div(T_LOCK_DDR3_NS, CLK_PERIOD_NS);
   localparam int LKG_CYC   = ceil_div(T_LOCK_GDDR3_NS, CLK_PERIOD_NS);
   localparam int SRE_CYC   = ceil_div(T_SR_ENTRY_NS, CLK_PERIOD_NS);
   localparam int SRX_CYC   = ceil_div(T_CLK_STABLE_NS, CLK_PERIOD_NS);
   localparam int XS_CYC    = ceil_div(T_SR_EXIT_NS, CLK_PERIOD_NS);
   localparam int CNT_LIMIT = 2 ** CNT_W;

   if (MR_W < 9) begin : g_chk_mrw
      $error("reclk_seq: MR_W must hold bit 8");
   end
   if (CLK_PERIOD_NS < 1) begin : g_chk_period
      $error("reclk_seq: CLK_PERIOD_NS must be positive");
   end
   if (MRD_CYC >= CNT_LIMIT || LK2_CYC >= CNT_LIMIT || LK3_CYC >= CNT_LIMIT ||
       LKG_CYC >= CNT_LIMIT || SRE_CYC >= CNT_LIMIT || SRX_CYC >= CNT_LIMIT ||
       XS_CYC >= CNT_LIMIT) begin : g_chk_cnt
      $error("reclk_seq: CNT_W too narrow for a wait");
   end

   logic            busy_q;
   logic            err_q;
   step_t           step_q;
   logic [1:0]      typ_q;
   logic [MR_W-1:0] c0_q, c1_q, c2_q, t0_q, t1_q, t2_q;

   logic             en_v   [NSTEP];
   kind_e            kind_v [NSTEP];
   logic [2:0]       op_v   [NSTEP];
   logic [1:0]       sel_v  [NSTEP];
   logic [MR_W-1:0]  data_v [NSTEP];
   logic [CNT_W-1:0] wcyc_v [NSTEP];

   for (genvar g = 0; g < NSTEP; g++) begin : g_step
      reclk_step_decode #(
         .STEP_ID       (step_t'(g)),
         .MR_W          (MR_W),
         .CNT_W         (CNT_W),
         .MRD_CYC       (MRD_CYC),
         .LOCK_DDR2_CYC (LK2_CYC),
         .LOCK_DDR3_CYC (LK3_CYC),
         .LOCK_GDD3_CYC (LKG_CYC),
         .SRE_CYC       (SRE_CYC),
         .SRX_CYC       (SRX_CYC),
         .XS_CYC        (XS_CYC)
      ) u_dec (
         .typ  (typ_q),
         .cur0 (c0_q),
         .cur1 (c1_q),
         .cur2 (c2_q),
         .tgt0 (t0_q),
         .tgt1 (t1_q),
         .tgt2 (t2_q),
         .en   (en_v[g]),
         .kind (kind_v[g]),
         .op   (op_v[g]),
         .sel  (sel_v[g]),
         .data (data_v[g]),
         .wcyc (wcyc_v[g])
      );
   end

   kind_e cur_kind;
   step_t nxt_step;
   logic  timer_exp;
   logic  advance;

   assign cur_kind = kind_v[step_q];

   always_comb begin
      nxt_step = ST_FIN;
      for (int i = NSTEP - 1; i >= 1; i--) begin
         if (step_t'(i) > step_q && en_v[i]) nxt_step = step_t'(i);
      end
   end

   assign advance = busy_q && ((cur_kind == K_NOP) ||
                               (cur_kind == K_CMD && cmd_ready) ||
                               (cur_kind == K_WAIT && timer_exp));

   reclk_wait_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (advance || !busy_q),
      .run     (busy_q && cur_kind == K_WAIT),
      .limit   (wcyc_v[step_q]),
      .expired (timer_exp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         err_q  <= 1'b0;
         step_q <= ST_BEGIN;
         typ_q  <= MT_DDR2;
         c0_q   <= '0;
         c1_q   <= '0;
         c2_q   <= '0;
         t0_q   <= '0;
         t1_q   <= '0;
         t2_q   <= '0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q <= 1'b1;
            err_q  <= (mem_type == MT_OTHER);
            step_q <= (mem_type == MT_OTHER) ? ST_FIN : ST_BEGIN;
            typ_q  <= mem_type;
            c0_q   <= cur_mr0;
            c1_q   <= cur_mr1;
            c2_q   <= (mem_type == MT_DDR2) ? tgt_mr2 : cur_mr2;
            t0_q   <= tgt_mr0;
            t1_q   <= tgt_mr1;
            t2_q   <= tgt_mr2;
         end
      end else if (step_q == ST_FIN) begin
         busy_q <= 1'b0;
      end else if (advance) begin
         step_q <= nxt_step;
      end
   end

   assign cmd_valid = busy_q && (cur_kind == K_CMD);
   assign cmd_op    = op_v[step_q];
   assign cmd_sel   = sel_v[step_q];
   assign cmd_data  = data_v[step_q];
   assign done      = busy_q && (step_q == ST_FIN);
   assign err       = err_q;

endmodule

// File: rtl/reclk_seq_chk.sv
module reclk_seq_chk #(
   parameter int MR_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cmd_valid,
   input logic            cmd_ready,
   input logic [2:0]      cmd_op,
   input logic [1:0]      cmd_sel,
   input logic [MR_W-1:0] cmd_data,
   input logic            done,
   input logic            err
);

   logic in_sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) in_sr_q <= 1'b0;
      else if (cmd_valid && cmd_ready && cmd_op == 3'd3) in_sr_q <= cmd_data[0];
   end

   // R10: an offered command holds until taken
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) &&
                                  $stable(cmd_sel) && $stable(cmd_data));

   // R11: done lasts one cycle and never overlaps a command
   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r11_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !cmd_valid);

   // R1: an error run stays silent
   a_r1_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !cmd_valid);

   // R4: clock change only while parked in self-refresh
   a_r4_clk_in_sr: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_op == 3'd5 |-> in_sr_q);

   // R5: auto-refresh re-enabled only after self-refresh exit
   a_r5_auto_after_exit: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_op == 3'd2 && cmd_data[0] |-> !in_sr_q);

   // R6: only three mode registers are addressed
   a_r6_mr_index: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_op == 3'd4 |-> cmd_sel != 2'd3);

endmodule

bind reclk_seq reclk_seq_chk #(.MR_W(MR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_op    (cmd_op),
   .cmd_sel   (cmd_sel),
   .cmd_data  (cmd_data),
   .done      (done),
   .err       (err)
);

// File: tb/reclk_seq_tb.sv
`timescale 1ns/1ps
module reclk_seq_tb;

   localparam int MW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [1:0]    mem_type = 2'd0;
   logic [MW-1:0] cur_mr0 = '0, cur_mr1 = '0, cur_mr2 = '0;
   logic [MW-1:0] tgt_mr0 = '0, tgt_mr1 = '0, tgt_mr2 = '0;
   logic          cmd_valid, cmd_ready = 1'b0;
   logic [2:0]    cmd_op;
   logic [1:0]    cmd_sel;
   logic [MW-1:0] cmd_data;
   logic          done, err;

   always #10 clk = ~clk;

   reclk_seq #(.MR_W(MW)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mem_type(mem_type),
      .cur_mr0(cur_mr0), .cur_mr1(cur_mr1), .cur_mr2(cur_mr2),
      .tgt_mr0(tgt_mr0), .tgt_mr1(tgt_mr1), .tgt_mr2(tgt_mr2),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
      .cmd_sel(cmd_sel), .cmd_data(cmd_data), .done(done), .err(err)
   );

   typedef struct {
      int            kind;   // 0 command, 1 wait
      int            op;
      int            sel;
      logic [MW-1:0] data;
      int            cyc;
      string         req;
   } item_t;

   item_t q[$];
   int    n_chk = 0, n_fail = 0;
   bit    m_busy = 0, m_err = 0;
   int    m_phase = 0, wcnt = 0, rdy_mode = 0, cyc_no = 0;
   logic  start_req = 1'b0;

   function automatic int ns2cyc(int ns);
      return (ns + 19) / 20;
   endfunction

   task automatic chk(bit ok, string r, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", r, what, act, exp, cyc_no);
      end
   endtask

   task automatic pc(int op, int sel, logic [MW-1:0] d, string r);
      item_t it;
      it.kind = 0; it.op = op; it.sel = sel; it.data = d; it.cyc = 0; it.req = r;
      q.push_back(it);
   endtask

   task automatic pw(int ns, string r);
      item_t it;
      it.kind = 1; it.op = 0; it.sel = 0; it.data = '0; it.cyc = ns2cyc(ns); it.req = r;
      if (it.cyc > 0) q.push_back(it);
   endtask

   // expected stream built from the requirements
   task automatic build();
      logic [MW-1:0] flag, c2;
      bit c_off, t_off;
      int lock;
      string mtag;
      flag  = (mem_type == 2) ? MW'(16'h0040) : MW'(16'h0001);   // R2
      c2    = (mem_type == 0) ? tgt_mr2 : cur_mr2;                // R8
      c_off = |(cur_mr1 & flag);
      t_off = |(tgt_mr1 & flag);
      lock  = (mem_type == 0) ? 2000 : (mem_type == 1) ? 12000 : 40000;
      mtag  = (mem_type == 0) ? "R8" : "R6";
      q.delete();
      if (!c_off && t_off) begin
         pc(0, 0, '0, "R3");
         pc(4, 1, cur_mr1 | flag, "R2");
         pw(1000, "R3");
      end
      pc(0, 0, '0, "R4"); pc(1, 0, '0, "R4"); pc(1, 0, '0, "R4");
      pc(2, 0, '0, "R4"); pc(3, 0, MW'(1), "R4");
      if (mem_type == 1) pw(2000, "R9");
      pc(5, 0, '0, "R4");
      pc(0, 0, '0, "R5"); pc(3, 0, '0, "R5"); pc(2, 0, MW'(1), "R5");
      if (mem_type == 1) begin pw(1000, "R9"); pw(1000, "R9"); end
      if (c2 != tgt_mr2) begin pc(4, 2, tgt_mr2, mtag); pw(1000, "R9"); end
      if (cur_mr1 != tgt_mr1) begin
         pc(4, 1, tgt_mr1 | (cur_mr1 & flag), mtag); pw(1000, "R9");
      end
      if (cur_mr0 != tgt_mr0) begin pc(4, 0, tgt_mr0, mtag); pw(1000, "R9"); end
      pc(6, 0, '0, mtag);
      if (!t_off) begin
         if (c_off) begin pc(4, 1, tgt_mr1, "R7"); pw(1000, "R7"); end
         pc(4, 0, tgt_mr0 | MW'(16'h0100), "R7"); pw(1000, "R7");
         pc(4, 0, tgt_mr0, "R7"); pw(1000, "R7");
         pw(lock, "R9");
         if (mem_type == 2) pc(0, 0, '0, "R7");
      end
   endtask

   task automatic tick();
      bit ev, ed;
      string tag;
      @(negedge clk);
      cyc_no++;
      ev  = m_busy && m_phase == 1 && q.size() > 0 && q[0].kind == 0;
      ed  = m_busy && m_phase == 2;
      tag = ev ? "R10" : (m_busy && m_phase == 1 && q.size() > 0) ? q[0].req : "R11";
      chk(cmd_valid == ev, tag, "cmd_valid", int'(cmd_valid), int'(ev));
      if (ev && cmd_valid)
         chk(cmd_op == 3'(q[0].op) && cmd_sel == 2'(q[0].sel) && cmd_data == q[0].data,
             q[0].req, "op/sel/data", {cmd_op, cmd_sel, cmd_data},
             {3'(q[0].op), 2'(q[0].sel), q[0].data});
      chk(done == ed, "R11", "done", int'(done), int'(ed));
      chk(err == m_err, "R1", "err", int'(err), int'(m_err));
      cmd_ready = (rdy_mode == 0) ? 1'b1 : (cyc_no % 3 == 0);
      start     = start_req;
      start_req = 1'b0;
      if (!m_busy) begin
         if (start) begin
            m_busy = 1;
            m_err  = (mem_type == 2'd3);
            if (m_err) m_phase = 2;
            else begin build(); m_phase = 0; end
         end
      end else begin
         case (m_phase)
            0: m_phase = 1;
            1: begin
               if (q[0].kind == 0) begin
                  if (cmd_ready) void'(q.pop_front());
               end else begin
                  wcnt++;
                  if (wcnt == q[0].cyc) begin wcnt = 0; void'(q.pop_front()); end
               end
               if (q.size() == 0) m_phase = 2;
            end
            default: m_busy = 0;
         endcase
      end
   endtask

   task automatic run(int typ, int c0, int c1, int c2, int t0, int t1, int t2,
                      int rmode, int poke);
      int g;
      mem_type = 2'(typ);
      cur_mr0 = MW'(c0); cur_mr1 = MW'(c1); cur_mr2 = MW'(c2);
      tgt_mr0 = MW'(t0); tgt_mr1 = MW'(t1); tgt_mr2 = MW'(t2);
      rdy_mode  = rmode;
      start_req = 1'b1;
      tick();
      g = 0;
      while (m_busy) begin
         // R11: start while busy (mid-run or in the done cycle) must be ignored
         if ((poke > 0 && g == poke) || (poke < 0 && m_phase == 2)) begin
            start_req = 1'b1;
            mem_type  = 2'd3;
         end
         tick();
         g++;
         if (g > 60000) begin
            chk(1'b0, "R11", "watchdog", g, 0);
            break;
         end
      end
      repeat (3) tick();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) tick();                                   // reset state R1 R11
      // R8: DDR2, only MR0 changes, MR2 difference ignored
      run(0, 'h0432, 'h0004, 'h0000, 'h0552, 'h0004, 'h0080, 0, 0);
      // R3 R9: DDR3 DLL on->off, all MRs change, stalled ready R10
      run(1, 'h1210, 'h0000, 'h0008, 'h1420, 'h0041, 'h0018, 1, 0);
      // R2 R7: GDDR3 DLL off->on (bit 0 in target is not the flag), start poke
      run(2, 'h0230, 'h0040, 'h0003, 'h0230, 'h0011, 'h0007, 0, 30);
      // R1: unsupported type
      run(3, 'h0, 'h0, 'h0, 'h1, 'h1, 'h1, 0, 0);
      // R6 R9: DDR3 no MR change, DLL stays on, stalled ready
      run(1, 'h0520, 'h0004, 'h0010, 'h0520, 'h0004, 'h0010, 1, 0);
      // R2 R3: GDDR3 DLL on->off via bit 6, start poke in done cycle
      run(2, 'h0111, 'h0001, 'h0002, 'h0121, 'h0041, 'h0002, 0, -1);
      // R7: DDR2 DLL off->on
      run(0, 'h0642, 'h0001, 'h0000, 'h0642, 'h0000, 'h0000, 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule